// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of translation tables from memory. A walk starts with one start pulse. The pulse carries the virtual address, the base of the top-level table (the directory) and the kind of access wanted. The walker first reads the directory entry selected by the upper ten address bits. If that entry is present and allows the access, it then reads the leaf-table entry selected by the next ten bits. The upper twenty bits of the leaf entry, joined with the untouched 12-bit page offset, form the physical address.

The memory port is word-addressed and its latency can vary. The walker raises a read request, holds the address steady, and waits for the read-valid strobe. Every entry uses the same layout:
- bit 0: present
- bit 1: writable
- bit 2: user-accessible
- bit 3: executable
- bits [31:12]: the frame base

A walk ends with a one-cycle done pulse. The pulse carries either the physical address or a fault code that tells apart a missing directory entry, a missing leaf entry, and a rights violation.

Top module: `ptab_walker`

## Requirements
- R1: While reset is active and on the first cycles after it, `walk_done` and `mem_rd_req` are 0.
- R2: The first read goes to word address {`walk_root`[31:12], `walk_vaddr`[31:22]}; the low 12 bits of `walk_root` are ignored. The second read goes to {directory entry[31:12], `walk_vaddr`[21:12]}. While `mem_rd_req` is high and no `mem_rd_valid` has arrived, the request and the address stay unchanged.
- R3: A walk whose two entries are present and permit the access ends with `walk_fault` = 0 and `walk_paddr` = {leaf entry[31:12], `walk_vaddr`[11:0]}.
- R4: A directory entry with bit 0 clear ends the walk after one read with `walk_fault` = 1.
- R5: A leaf entry with bit 0 clear ends the walk after two reads with `walk_fault` = 2, even when its rights bits would also deny the access.
- R6: The access kind `walk_kind` is encoded as follows: 0 is read (needs only the present bit), 1 is write (needs bit 1), 2 is execute (needs bit 3), and 3 is reserved (always denied). With `walk_user` = 1, bit 2 is also needed. The access is checked at both levels. A denial ends the walk with `walk_fault` = 3, after one read if the directory entry denies it and after two reads if the leaf entry denies it. On any fault `walk_paddr` is 0.
- R7: `walk_done` is high for exactly one cycle, in the cycle after the edge that accepts the final read. With a memory that answers L cycles after it first sees a request, the pulse comes 3+L cycles after the start edge for a one-read walk and 5+2L cycles after it for a two-read walk.
- R8: A start pulse while a walk is in progress has no effect on that walk. A `mem_rd_valid` while no read is pending produces no done pulse and no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| walk_start | input | 1 | Begins a walk when the walker is idle |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_root | input | 32 | Byte base of the directory table |
| walk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| walk_user | input | 1 | 1 for a user-mode access, 0 for kernel |
| walk_done | output | 1 | One-cycle pulse when the result is ready |
| walk_paddr | output | 32 | Physical address, valid with walk_done, 0 on fault |
| walk_fault | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 rights |
| mem_rd_req | output | 1 | Read request, held until mem_rd_valid |
| mem_rd_addr | output | 30 | Word address of the entry being read |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Entry returned by memory |

## Verification
The hardest case to reach from the ports is a denial that differs by level. The same access must be refused by the directory entry (one read) in one walk and by the leaf entry (two reads) in another. The memory image is therefore built so that directory entries with restricted rights point into leaf tables that hold both permissive and restrictive leaves. Each case also runs under a different memory latency, so that the read count, both read addresses and the timing of the done pulse are checked against values worked out by hand. Two directed tests cover the rest: a start pulse in the middle of a slow walk, and a stray read strobe while the walker is idle.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

  localparam int ADDR_W      = 32;
  localparam int PAGE_SH     = 12;
  localparam int ENTRY_BYTES = 4;
  localparam int WORD_SH     = $clog2(ENTRY_BYTES);
  localparam int WORD_W      = ADDR_W - WORD_SH;
  localparam int FRAME_W     = ADDR_W - PAGE_SH;
  localparam int IDX_W       = PAGE_SH - WORD_SH;

  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;
  localparam int BIT_EXE  = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DIR   = 2'd1,
    FLT_LEAF  = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_LEAF = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  // word address of the directory entry for a virtual address
  function automatic logic [WORD_W-1:0] dir_word(input logic [ADDR_W-1:0] root,
                                                 input logic [ADDR_W-1:0] va);
    return {root[ADDR_W-1:PAGE_SH], va[ADDR_W-1 -: IDX_W]};
  endfunction

  // word address of the leaf entry inside the table at frame base
  function automatic logic [WORD_W-1:0] leaf_word(input logic [FRAME_W-1:0] frame,
                                                  input logic [ADDR_W-1:0] va);
    return {frame, va[PAGE_SH +: IDX_W]};
  endfunction

  // frame of an entry joined with the page offset
  function automatic logic [ADDR_W-1:0] join_frame(input logic [ADDR_W-1:0] entry,
                                                   input logic [ADDR_W-1:0] va);
    return {entry[ADDR_W-1:PAGE_SH], va[PAGE_SH-1:0]};
  endfunction

  // does one entry allow the requested access
  function automatic logic rights_ok(input logic [ADDR_W-1:0] entry,
                                     input acc_kind_e kind,
                                     input logic user);
    logic ok;
    case (kind)
      ACC_READ:  ok = 1'b1;
      ACC_WRITE: ok = entry[BIT_WR];
      ACC_EXEC:  ok = entry[BIT_EXE];
      default:   ok = 1'b0;
    endcase
    if (user && !entry[BIT_USR]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/ptab_rights.sv
module ptab_rights
  import ptab_pkg::*;
(
  input  logic [ADDR_W-1:0] entry,
  input  acc_kind_e         kind,
  input  logic              user,
  output logic              present,
  output logic              grant
);

  always_comb begin
    present = entry[BIT_PRES];
    grant   = rights_ok(entry, kind, user);
  end

endmodule

// File: rtl/ptab_addr.sv
module ptab_addr
  import ptab_pkg::*;
(
  input  logic               sel_leaf,
  input  logic [ADDR_W-1:0]  root,
  input  logic [ADDR_W-1:0]  va,
  input  logic [FRAME_W-1:0] frame,
  output logic [WORD_W-1:0]  word_addr
);

  logic [WORD_W-1:0] dir_a;
  logic [WORD_W-1:0] leaf_a;

  always_comb begin
    dir_a     = dir_word(root, va);
    leaf_a    = leaf_word(frame, va);
    word_addr = sel_leaf ? leaf_a : dir_a;
  end

endmodule

// File: rtl/ptab_ctrl.sv
module ptab_ctrl
  import ptab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_va,
  input  logic [ADDR_W-1:0]  start_root,
  input  acc_kind_e          start_kind,
  input  logic               start_user,
  input  logic               rd_valid,
  input  logic [ADDR_W-1:0]  rd_data,
  input  logic               ent_present,
  input  logic               ent_grant,
  output logic               rd_req,
  output logic               sel_leaf,
  output logic [ADDR_W-1:0]  va_q,
  output logic [ADDR_W-1:0]  root_q,
  output logic [FRAME_W-1:0] frame_q,
  output acc_kind_e          kind_q,
  output logic               user_q,
  output logic               done,
  output logic [ADDR_W-1:0]  paddr,
  output fault_e             fault
);

  walk_state_e       state_q;
  logic [ADDR_W-1:0] paddr_q;
  fault_e            fault_q;

  // named internal events
  logic take_start;
  logic dir_accept;
  logic leaf_accept;

  always_comb begin
    take_start  = start && (state_q == ST_IDLE);
    dir_accept  = rd_valid && (state_q == ST_DIR);
    leaf_accept = rd_valid && (state_q == ST_LEAF);
    rd_req      = (state_q == ST_DIR) || (state_q == ST_LEAF);
    sel_leaf    = (state_q == ST_LEAF);
    done        = (state_q == ST_DONE);
    paddr       = paddr_q;
    fault       = fault_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      frame_q <= '0;
      kind_q  <= ACC_READ;
      user_q  <= 1'b0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            va_q    <= start_va;
            root_q  <= start_root;
            kind_q  <= start_kind;
            user_q  <= start_user;
            state_q <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (dir_accept) begin
            if (!ent_present) begin
              fault_q <= FLT_DIR;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else if (!ent_grant) begin
              fault_q <= FLT_PROT;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else begin
              frame_q <= rd_data[ADDR_W-1:PAGE_SH];
              state_q <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (leaf_accept) begin
            if (!ent_present) begin
              fault_q <= FLT_LEAF;
              paddr_q <= '0;
            end else if (!ent_grant) begin
              fault_q <= FLT_PROT;
              paddr_q <= '0;
            end else begin
              fault_q <= FLT_NONE;
              paddr_q <= join_frame(rd_data, va_q);
            end
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req);

  p_fault_zero_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != FLT_NONE) |-> (paddr == '0));

  p_dir_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_accept && !ent_present) |=> (done && fault == FLT_DIR));

  p_leaf_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (leaf_accept && !ent_present) |=> (done && fault == FLT_LEAF));

  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(va_q) && $stable(kind_q) && $stable(user_q)));

  p_idle_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !done);

endmodule

// File: rtl/ptab_walker.sv
module ptab_walker
  import ptab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [31:0]       walk_vaddr,
  input  logic [31:0]       walk_root,
  input  logic [1:0]        walk_kind,
  input  logic              walk_user,
  output logic              walk_done,
  output logic [31:0]       walk_paddr,
  output logic [1:0]        walk_fault,
  output logic              mem_rd_req,
  output logic [29:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data
);

  logic               sel_leaf;
  logic [ADDR_W-1:0]  va_q;
  logic [ADDR_W-1:0]  root_q;
  logic [FRAME_W-1:0] frame_q;
  acc_kind_e          kind_q;
  logic               user_q;
  logic               ent_present;
  logic               ent_grant;
  fault_e             fault_w;
  logic [WORD_W-1:0]  word_addr;

  ptab_rights u_rights (
    .entry   (mem_rd_data),
    .kind    (kind_q),
    .user    (user_q),
    .present (ent_present),
    .grant   (ent_grant)
  );

  ptab_addr u_addr (
    .sel_leaf  (sel_leaf),
    .root      (root_q),
    .va        (va_q),
    .frame     (frame_q),
    .word_addr (word_addr)
  );

  ptab_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (walk_start),
    .start_va    (walk_vaddr),
    .start_root  (walk_root),
    .start_kind  (acc_kind_e'(walk_kind)),
    .start_user  (walk_user),
    .rd_valid    (mem_rd_valid),
    .rd_data     (mem_rd_data),
    .ent_present (ent_present),
    .ent_grant   (ent_grant),
    .rd_req      (mem_rd_req),
    .sel_leaf    (sel_leaf),
    .va_q        (va_q),
    .root_q      (root_q),
    .frame_q     (frame_q),
    .kind_q      (kind_q),
    .user_q      (user_q),
    .done        (walk_done),
    .paddr       (walk_paddr),
    .fault       (fault_w)
  );

  assign mem_rd_addr = word_addr;
  assign walk_fault  = fault_w;

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> $stable(mem_rd_addr));

  p_write_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && ent_grant && kind_q == ACC_WRITE)
      |-> mem_rd_data[BIT_WR]);

  p_user_needs_usr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && ent_grant && user_q) |-> mem_rd_data[BIT_USR]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!walk_done && !mem_rd_req));

endmodule

// File: tb/sim_ptab_walker.sv
`timescale 1ns/1ps
module sim_ptab_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_start = 1'b0;
  logic [31:0] walk_vaddr = '0;
  logic [31:0] walk_root = 32'h0000_1ABC;
  logic [1:0]  walk_kind = '0;
  logic        walk_user = 1'b0;
  logic        walk_done;
  logic [31:0] walk_paddr;
  logic [1:0]  walk_fault;
  logic        mem_rd_req;
  logic [29:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  always #2.5 clk = ~clk;

  ptab_walker u0 (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_vaddr(walk_vaddr),
    .walk_root(walk_root), .walk_kind(walk_kind), .walk_user(walk_user),
    .walk_done(walk_done), .walk_paddr(walk_paddr), .walk_fault(walk_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  // memory model: answers lat cycles after it first sees a request
  logic [31:0] mem [4096];
  logic [3:0]  lat = '0;
  logic [3:0]  cnt;
  logic        mv;
  logic        spur = 1'b0;
  logic        clr = 1'b0;
  logic        bad_addr;
  logic [1:0]  reads;
  logic [29:0] a1, a2;
  logic [31:0] mdata;

  assign mem_rd_valid = mv | spur;
  assign mem_rd_data  = mdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      mv <= 1'b0; cnt <= '0; bad_addr <= 1'b0; reads <= '0; mdata <= '0;
      a1 <= '0; a2 <= '0;
    end else begin
      if (clr) begin
        reads <= '0; bad_addr <= 1'b0;
      end else if (mem_rd_req && mem_rd_valid) begin
        reads <= reads + 2'd1;
        if (reads == 2'd0) a1 <= mem_rd_addr; else a2 <= mem_rd_addr;
      end
      if (mv) begin
        mv <= 1'b0; cnt <= '0;
      end else if (mem_rd_req) begin
        if (cnt >= lat) begin
          mv    <= 1'b1;
          mdata <= mem[mem_rd_addr[11:0]];
          if (mem_rd_addr[29:12] != '0) bad_addr <= 1'b1;
        end else begin
          cnt <= cnt + 4'd1;
        end
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
    logic [3:0]  lat;
    logic [1:0]  fault;
    logic [31:0] pa;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0123, 2'd0, 1'b1, 4'd0, 2'd0, 32'h1234_5123, 2'd2},
    '{32'h0000_0FFF, 2'd1, 1'b0, 4'd3, 2'd0, 32'h1234_5FFF, 2'd2},
    '{32'h0000_1010, 2'd0, 1'b1, 4'd1, 2'd0, 32'hABCD_E010, 2'd2},
    '{32'h0000_1010, 2'd1, 1'b1, 4'd2, 2'd3, 32'h0000_0000, 2'd2},
    '{32'h0000_2000, 2'd0, 1'b0, 4'd0, 2'd2, 32'h0000_0000, 2'd2},
    '{32'h0080_0000, 2'd0, 1'b0, 4'd4, 2'd1, 32'h0000_0000, 2'd1},
    '{32'h0040_0ABC, 2'd0, 1'b0, 4'd1, 2'd0, 32'hCAFE_0ABC, 2'd2},
    '{32'h0040_0ABC, 2'd0, 1'b1, 4'd0, 2'd3, 32'h0000_0000, 2'd1},
    '{32'h0040_0ABC, 2'd2, 1'b0, 4'd2, 2'd3, 32'h0000_0000, 2'd1},
    '{32'h0000_3456, 2'd2, 1'b0, 4'd0, 2'd0, 32'h0F0F_0456, 2'd2},
    '{32'h0000_3456, 2'd2, 1'b1, 4'd1, 2'd3, 32'h0000_0000, 2'd2},
    '{32'h00C0_4000, 2'd1, 1'b0, 4'd0, 2'd3, 32'h0000_0000, 2'd1},
    '{32'h00C0_1777, 2'd0, 1'b1, 4'd3, 2'd0, 32'hABCD_E777, 2'd2},
    '{32'h0000_0123, 2'd3, 1'b0, 4'd0, 2'd3, 32'h0000_0000, 2'd1},
    '{32'h0000_4008, 2'd1, 1'b0, 4'd5, 2'd0, 32'h7777_7008, 2'd2}
  };

  // walk result as seen at the ports
  logic [31:0] r_pa;
  logic [1:0]  r_flt;
  int          r_cyc;

  // drives one walk starting at a negedge; returns at the negedge after the pulse
  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic user,
                      input logic [3:0] l, input bit poke_busy);
    bit seen = 1'b0;
    lat = l;
    walk_vaddr = va; walk_kind = kind; walk_user = user;
    walk_start = 1'b1; clr = 1'b1;
    @(negedge clk);
    walk_start = 1'b0; clr = 1'b0;
    r_cyc = 1;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (walk_done) begin
        seen = 1'b1;
      end else begin
        if (poke_busy && r_cyc == 2) begin
          walk_vaddr = 32'h0080_0000; walk_kind = 2'd3; walk_user = 1'b1;
          walk_start = 1'b1;
        end else begin
          walk_start = 1'b0;
        end
        @(negedge clk);
        r_cyc++;
      end
    end
    walk_start = 1'b0;
    if (!seen) begin
      chk(1'b0, "R7 watchdog: no done pulse", 32'd0, 32'd1);
      finish_run();
    end
    r_pa  = walk_paddr;
    r_flt = walk_fault;
    @(negedge clk);
    chk(!walk_done, "R7 done lasts one cycle", {31'd0, walk_done}, 32'd0);
  endtask

  function automatic logic [29:0] exp_leaf_word(input logic [31:0] va);
    logic [29:0] base;
    base = (va[31:22] == 10'd1) ? 30'h0C00 : 30'h0800;
    return base + {20'd0, va[21:12]};
  endfunction

  initial begin
    #1_000_000;
    chk(1'b0, "R7 global watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // directory at word 0x400
    mem[12'h400] = 32'h0000_200F;
    mem[12'h401] = 32'h0000_3001;
    mem[12'h402] = 32'h0000_0000;
    mem[12'h403] = 32'h0000_200D;
    // leaf table at word 0x800
    mem[12'h800] = 32'h1234_500F;
    mem[12'h801] = 32'hABCD_E005;
    mem[12'h802] = 32'h5555_5000;
    mem[12'h803] = 32'h0F0F_0009;
    mem[12'h804] = 32'h7777_7003;
    // leaf table at word 0xC00
    mem[12'hC00] = 32'hCAFE_000F;

    repeat (3) @(negedge clk);
    chk(!walk_done, "R1 done low in reset", {31'd0, walk_done}, 32'd0);
    chk(!mem_rd_req, "R1 no request in reset", {31'd0, mem_rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!walk_done && !mem_rd_req, "R1 quiet after reset",
        {30'd0, walk_done, mem_rd_req}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int exp_cyc;
      t = VECS[v];
      walk(t.va, t.kind, t.user, t.lat, 1'b0);
      chk(r_flt == t.fault, $sformatf("R4 R5 R6 fault code vec %0d", v),
          {30'd0, r_flt}, {30'd0, t.fault});
      chk(r_pa == t.pa, $sformatf("R3 R6 paddr vec %0d", v), r_pa, t.pa);
      chk(reads == t.nrd, $sformatf("R4 R6 read count vec %0d", v),
          {30'd0, reads}, {30'd0, t.nrd});
      chk(a1 == 30'h400 + {20'd0, t.va[31:22]}, $sformatf("R2 dir address vec %0d", v),
          {2'd0, a1}, {2'd0, 30'h400 + {20'd0, t.va[31:22]}});
      if (t.nrd == 2'd2)
        chk(a2 == exp_leaf_word(t.va), $sformatf("R2 leaf address vec %0d", v),
            {2'd0, a2}, {2'd0, exp_leaf_word(t.va)});
      chk(!bad_addr, $sformatf("R2 address range vec %0d", v),
          {31'd0, bad_addr}, 32'd0);
      exp_cyc = (t.nrd == 2'd1) ? 3 + int'(t.lat) : 5 + 2 * int'(t.lat);
      chk(r_cyc == exp_cyc, $sformatf("R7 done timing vec %0d", v), r_cyc, exp_cyc);
    end

    // R8: start pulses during a slow walk are ignored
    walk(32'h0000_0123, 2'd0, 1'b1, 4'd6, 1'b1);
    chk(r_flt == 2'd0, "R8 busy start ignored fault", {30'd0, r_flt}, 32'd0);
    chk(r_pa == 32'h1234_5123, "R8 busy start ignored paddr", r_pa, 32'h1234_5123);
    chk(reads == 2'd2, "R8 busy start ignored reads", {30'd0, reads}, 32'd2);
    repeat (2) @(negedge clk);
    chk(!walk_done && !mem_rd_req, "R8 no second walk after busy start",
        {30'd0, walk_done, mem_rd_req}, 32'd0);

    // R8: stray read strobe while idle
    spur = 1'b1;
    @(negedge clk);
    spur = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!walk_done && !mem_rd_req, "R8 stray valid ignored",
          {30'd0, walk_done, mem_rd_req}, 32'd0);
      @(negedge clk);
    end
    walk(32'h00C0_1777, 2'd0, 1'b1, 4'd0, 1'b0);
    chk(r_pa == 32'hABCD_E777 && r_flt == 2'd0, "R8 R3 walk after stray valid",
        r_pa, 32'hABCD_E777);

    finish_run();
  end

endmodule